// File: doc/BRIEF.md
# Iterative Single-Precision Square Root Unit

This unit takes one IEEE 754 binary32 operand and returns its square root as a binary32 value. The value is rounded in one of five modes, and the unit reports the matching exception flags. The root comes from a digit-by-digit radix-2 recurrence. Each clock retires one root bit, and the unit keeps 25 bits: 24 significand bits and one round bit. Whatever is left in the remainder supplies the sticky bit. Before the recurrence starts, a subnormal operand is normalised with a leading-zero count. If the unbiased exponent is odd, the significand moves left one place and the exponent drops by one, so that halving the exponent gives an integer. The result exponent is therefore always in normal range.

The caller raises `start` with `operand` and `rmode` while `busy` is low. The unit then steps through five states. S_IDLE moves to S_PREP when start is accepted. S_PREP goes to S_ITER for a positive finite non-zero operand and straight to S_FIN for every special operand. S_ITER stays put until the last root bit is retired, then moves to S_ROUND. S_ROUND always goes to S_FIN. S_FIN always returns to S_IDLE. `done` is high only in S_FIN, and `result` and `flags` hold their values until the next operation completes.

Top module: `fsqrt_core`

## Requirements
- R1: After reset, busy, done, result and flags are all zero.
- R2: busy rises on the edge that samples start in S_IDLE and stays high through the done cycle. done is high after the 27th rising edge following that sampling edge for a positive finite non-zero operand, and after the 1st such edge for any special operand.
- R3: done is high for exactly one cycle per accepted operation. A start raised while busy is ignored: it changes neither the result nor the timing, and it gets no done of its own.
- R4: For a positive normal operand, result is the correctly rounded square root for both even and odd unbiased exponents. Exact roots (4.0→2.0, 9.0→3.0, 1.0→1.0) raise no flag in any mode.
- R5: Subnormal operands are normalised before the recurrence. For example 0x00000001→0x1A3504F3 with inexact, 0x00000002→0x1A800000 exact, and 0x00400000→0x1FB504F3 with inexact (round to nearest even).
- R6: rmode codes are 0 nearest-even, 1 toward zero, 2 downward, 3 upward and 4 nearest-max-magnitude. Codes 5 to 7 behave as code 0. For 0x3F800002 the results are 01/00/00/01/01 (low byte, high bytes 0x3F8000). For 0x3F800001 they are 00 for code 0, 00 for code 4 and 01 for code 3.
- R7: flags is {invalid[4], divide-by-zero[3], overflow[2], underflow[1], inexact[0]}. Bits 3..1 are never set. Inexact is set exactly when the round bit or the remainder is non-zero, and never together with invalid.
- R8: A round-up that carries out of the significand increments the exponent. For example 0x407FFFFF in upward mode gives 0x40000000, while nearest-even gives 0x3FFFFFFF.
- R9: +0 returns +0 and −0 returns −0, with no flag.
- R10: +infinity returns +infinity with no flag.
- R11: Any negative non-zero, non-NaN operand (normal, subnormal or −infinity) returns 0x7FC00000 and sets invalid only.
- R12: A quiet NaN of either sign returns 0x7FC00000 with no flag. A signalling NaN (top fraction bit clear) returns 0x7FC00000 with invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation; sampled only while busy is low |
| operand | input | 32 | binary32 operand, sampled with start |
| rmode | input | 3 | Rounding mode code, sampled with start |
| busy | output | 1 | High from acceptance through the done cycle |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | binary32 square root, held until the next completion |
| flags | output | 5 | Exception flags, held with result |

## Verification
On every cycle the assertions check the control handshake: an accepted start raises busy, busy cannot drop before done, and done never lasts two cycles. They also check, whenever done is high, that the flag word never shows overflow, underflow or divide-by-zero, that an invalid result is the canonical NaN, and that invalid never appears together with inexact. Only the bench's scenarios can show that the numerical values are right. That covers odd-exponent correction, subnormal normalisation, the behaviour of each rounding mode, the carry into the exponent, and the exact latencies. The bench also shows that a start arriving mid-operation leaves no trace.

// File: rtl/fsqrt_pkg.sv
package fsqrt_pkg;
    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_TO_ZERO   = 3'd1,
        RM_DOWNWARD  = 3'd2,
        RM_UPWARD    = 3'd3,
        RM_NEAR_MAX  = 3'd4
    } rmode_e;

    typedef enum logic [2:0] {
        K_FINITE,
        K_ZERO,
        K_PINF,
        K_QNAN,
        K_SNAN,
        K_NEG
    } kind_e;

    localparam int FLAG_W      = 5;
    localparam int FLG_INVALID = 4;
    localparam int FLG_INEXACT = 0;
endpackage

// File: rtl/fsqrt_unpack.sv
module fsqrt_unpack
    import fsqrt_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W,
    localparam int SIG_W  = MAN_W + 1
) (
    input  logic [WORD_W-1:0] word,
    output kind_e             kind,
    output logic [SIG_W:0]    sig,
    output logic [EXP_W-1:0]  exp_out
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int EW   = EXP_W + 2;
    localparam int LZ_W = $clog2(SIG_W) + 1;
    localparam logic signed [EW-1:0] BIAS_S = EW'(BIAS);

    logic             sgn;
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] f;
    logic [LZ_W-1:0]  lz;
    logic             seen;
    logic [SIG_W-1:0] m;
    logic signed [EW-1:0] ue, ue_ev, half, bexp;
    logic             odd;
    logic [1:0]       unused_bexp_hi;

    assign sgn = word[WORD_W-1];
    assign e   = word[WORD_W-2:MAN_W];
    assign f   = word[MAN_W-1:0];

    always_comb begin
        if (&e) begin
            if (f == '0) kind = sgn ? K_NEG : K_PINF;
            else         kind = f[MAN_W-1] ? K_QNAN : K_SNAN;
        end else if (e == '0 && f == '0) begin
            kind = K_ZERO;
        end else begin
            kind = sgn ? K_NEG : K_FINITE;
        end
    end

    always_comb begin
        lz   = '0;
        seen = 1'b0;
        for (int i = MAN_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (f[i]) seen = 1'b1;
                else      lz   = lz + 1'b1;
            end
        end
    end

    always_comb begin
        if (e != '0) begin
            m  = {1'b1, f};
            ue = $signed({2'b00, e}) - BIAS_S;
        end else begin
            m  = {1'b0, f} << (lz + 1'b1);
            ue = -BIAS_S - $signed({{(EW-LZ_W){1'b0}}, lz});
        end
        odd   = ue[0];
        sig   = odd ? {m, 1'b0} : {1'b0, m};
        ue_ev = ue - $signed({{(EW-1){1'b0}}, odd});
        half  = ue_ev >>> 1;
        bexp  = half + BIAS_S;
    end

    assign exp_out        = bexp[EXP_W-1:0];
    assign unused_bexp_hi = bexp[EW-1:EXP_W];
endmodule

// File: rtl/fsqrt_step.sv
module fsqrt_step #(
    parameter int ROOT_W = 25,
    localparam int REM_W = ROOT_W + 3
) (
    input  logic [REM_W-1:0]  rem_i,
    input  logic [ROOT_W-1:0] root_i,
    input  logic [1:0]        pair,
    output logic [REM_W-1:0]  rem_o,
    output logic [ROOT_W-1:0] root_o
);
    logic [REM_W-1:0] rem_sh, trial;
    logic             ge;

    always_comb begin
        rem_sh = (rem_i << 2) | REM_W'(pair);
        trial  = {{(REM_W-ROOT_W-2){1'b0}}, root_i, 2'b01};
        ge     = rem_sh >= trial;
        rem_o  = ge ? rem_sh - trial : rem_sh;
        root_o = (root_i << 1) | ROOT_W'(ge);
    end
endmodule

// File: rtl/fsqrt_round.sv
module fsqrt_round
    import fsqrt_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W,
    localparam int ROOT_W = MAN_W + 2
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [ROOT_W-1:0] root_i,
    input  logic              sticky,
    input  rmode_e            mode,
    output logic [WORD_W-1:0] result,
    output logic              inexact
);
    logic lsb, rbit, inc, unused_hidden;

    assign lsb           = root_i[1];
    assign rbit          = root_i[0];
    assign unused_hidden = root_i[ROOT_W-1];

    always_comb begin
        case (mode)
            RM_TO_ZERO:  inc = 1'b0;
            RM_DOWNWARD: inc = 1'b0;
            RM_UPWARD:   inc = rbit | sticky;
            RM_NEAR_MAX: inc = rbit;
            default:     inc = rbit & (sticky | lsb);
        endcase
        result  = {1'b0, exp_i, root_i[ROOT_W-2:1]} + WORD_W'(inc);
        inexact = rbit | sticky;
    end
endmodule

// File: rtl/fsqrt_core.sv
module fsqrt_core
    import fsqrt_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [EXP_W+MAN_W:0]       operand,
    input  logic [2:0]                 rmode,
    output logic                       busy,
    output logic                       done,
    output logic [EXP_W+MAN_W:0]       result,
    output logic [fsqrt_pkg::FLAG_W-1:0] flags
);
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int ROOT_W = MAN_W + 2;
    localparam int RAD_W  = 2 * ROOT_W;
    localparam int REM_W  = ROOT_W + 3;
    localparam int CNT_W  = $clog2(ROOT_W);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(ROOT_W - 1);
    localparam logic [WORD_W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    typedef enum logic [2:0] {S_IDLE, S_PREP, S_ITER, S_ROUND, S_FIN} state_e;

    state_e              state, nstate;
    logic [WORD_W-1:0]   op_q;
    rmode_e              mode_q;
    logic [RAD_W-1:0]    rad_q;
    logic [REM_W-1:0]    rem_q, rem_n;
    logic [ROOT_W-1:0]   root_q, root_n;
    logic [CNT_W-1:0]    cnt_q;
    logic [EXP_W-1:0]    exp_q, u_exp;
    logic [ROOT_W-1:0]   u_sig;
    kind_e               u_kind;
    logic [WORD_W-1:0]   res_q, rnd_res;
    logic [FLAG_W-1:0]   flg_q;
    logic                rnd_nx;

    fsqrt_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
        .word(op_q), .kind(u_kind), .sig(u_sig), .exp_out(u_exp)
    );

    fsqrt_step #(.ROOT_W(ROOT_W)) u_step (
        .rem_i(rem_q), .root_i(root_q), .pair(rad_q[RAD_W-1 -: 2]),
        .rem_o(rem_n), .root_o(root_n)
    );

    fsqrt_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
        .exp_i(exp_q), .root_i(root_q), .sticky(|rem_q), .mode(mode_q),
        .result(rnd_res), .inexact(rnd_nx)
    );

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (start) nstate = S_PREP;
            S_PREP:  nstate = (u_kind == K_FINITE) ? S_ITER : S_FIN;
            S_ITER:  if (cnt_q == LAST) nstate = S_ROUND;
            S_ROUND: nstate = S_FIN;
            S_FIN:   nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        busy = (state != S_IDLE);
        done = (state == S_FIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            mode_q <= RM_NEAR_EVEN;
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
            cnt_q  <= '0;
            exp_q  <= '0;
            res_q  <= '0;
            flg_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    op_q   <= operand;
                    mode_q <= rmode_e'(rmode);
                end
                S_PREP: begin
                    rad_q  <= {u_sig, {ROOT_W{1'b0}}};
                    rem_q  <= '0;
                    root_q <= '0;
                    cnt_q  <= '0;
                    exp_q  <= u_exp;
                    case (u_kind)
                        K_ZERO, K_PINF: begin res_q <= op_q;  flg_q <= '0; end
                        K_QNAN:         begin res_q <= CANON; flg_q <= '0; end
                        K_SNAN, K_NEG:  begin
                            res_q <= CANON;
                            flg_q <= FLAG_W'(1) << FLG_INVALID;
                        end
                        default: ;
                    endcase
                end
                S_ITER: begin
                    rem_q  <= rem_n;
                    root_q <= root_n;
                    rad_q  <= rad_q << 2;
                    cnt_q  <= cnt_q + 1'b1;
                end
                S_ROUND: begin
                    res_q <= rnd_res;
                    flg_q <= FLAG_W'(rnd_nx) << FLG_INEXACT;
                end
                S_FIN: ;
            endcase
        end
    end

    assign result = res_q;
    assign flags  = flg_q;
endmodule

// File: rtl/fsqrt_core_chk.sv
module fsqrt_core_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] result,
    input logic [4:0]        flags
);
    localparam logic [WORD_W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_range_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags[3:1] == 3'b000));

    assert_invalid_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[4]) |-> !flags[0]);

    assert_nan_canon_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[4]) |-> (result == CANON));
endmodule

bind fsqrt_core fsqrt_core_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .result(result), .flags(flags)
);

// File: tb/fsqrt_core_test.sv
module fsqrt_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [2:0]  rmode = '0;
    logic        busy, done;
    logic [31:0] result;
    logic [4:0]  flags;

    int total = 0;
    int bad   = 0;

    localparam logic [31:0] QNAN = 32'h7FC00000;
    localparam int LAT_FIN = 27;
    localparam int LAT_SPC = 1;

    fsqrt_core uut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .rmode(rmode), .busy(busy), .done(done), .result(result), .flags(flags)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] op, input logic [2:0] rm,
                          input logic [31:0] exp_r, input logic [4:0] exp_f,
                          input int exp_lat, input string tag);
        int n;
        @(negedge clk);
        operand = op; rmode = rm; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 100) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
        check(n == exp_lat, "R2 latency", 32'(n), 32'(exp_lat));
        check(result == exp_r, {tag, " result"}, result, exp_r);
        check(flags == exp_f, {tag, " flags"}, 32'(flags), 32'(exp_f));
        @(posedge clk); @(negedge clk);
        check(!done && !busy, "R3 done single cycle", {30'd0, done, busy}, 32'd0);
    endtask

    task automatic t_reset;
        check(!busy && !done && result == 0 && flags == 0, "R1 reset state",
              result | 32'(flags) | {30'd0, busy, done}, 32'd0);
    endtask

    task automatic t_exact;
        run_op(32'h40800000, 3'd0, 32'h40000000, 5'h00, LAT_FIN, "R4 sqrt4 even");
        run_op(32'h41100000, 3'd0, 32'h40400000, 5'h00, LAT_FIN, "R4 sqrt9 odd");
        run_op(32'h3F800000, 3'd3, 32'h3F800000, 5'h00, LAT_FIN, "R4 sqrt1 up exact");
        run_op(32'h40000000, 3'd0, 32'h3FB504F3, 5'h01, LAT_FIN, "R4 R7 sqrt2 nearest");
    endtask

    task automatic t_modes;
        run_op(32'h3F800002, 3'd0, 32'h3F800001, 5'h01, LAT_FIN, "R6 near-even");
        run_op(32'h3F800002, 3'd1, 32'h3F800000, 5'h01, LAT_FIN, "R6 to-zero");
        run_op(32'h3F800002, 3'd2, 32'h3F800000, 5'h01, LAT_FIN, "R6 downward");
        run_op(32'h3F800002, 3'd3, 32'h3F800001, 5'h01, LAT_FIN, "R6 upward");
        run_op(32'h3F800002, 3'd4, 32'h3F800001, 5'h01, LAT_FIN, "R6 near-max");
        run_op(32'h3F800002, 3'd7, 32'h3F800001, 5'h01, LAT_FIN, "R6 reserved code");
        run_op(32'h3F800001, 3'd0, 32'h3F800000, 5'h01, LAT_FIN, "R6 below half near-even");
        run_op(32'h3F800001, 3'd4, 32'h3F800000, 5'h01, LAT_FIN, "R6 below half near-max");
        run_op(32'h3F800001, 3'd3, 32'h3F800001, 5'h01, LAT_FIN, "R6 below half upward");
        run_op(32'h40000000, 3'd3, 32'h3FB504F4, 5'h01, LAT_FIN, "R6 sqrt2 upward");
    endtask

    task automatic t_subnormal;
        run_op(32'h00000001, 3'd0, 32'h1A3504F3, 5'h01, LAT_FIN, "R5 min subnormal");
        run_op(32'h00000002, 3'd0, 32'h1A800000, 5'h00, LAT_FIN, "R5 subnormal even exact");
        run_op(32'h00400000, 3'd0, 32'h1FB504F3, 5'h01, LAT_FIN, "R5 top subnormal");
    endtask

    task automatic t_carry;
        run_op(32'h407FFFFF, 3'd3, 32'h40000000, 5'h01, LAT_FIN, "R8 carry upward");
        run_op(32'h407FFFFF, 3'd0, 32'h3FFFFFFF, 5'h01, LAT_FIN, "R8 no carry nearest");
    endtask

    task automatic t_specials;
        run_op(32'h00000000, 3'd3, 32'h00000000, 5'h00, LAT_SPC, "R9 plus zero");
        run_op(32'h80000000, 3'd0, 32'h80000000, 5'h00, LAT_SPC, "R9 minus zero");
        run_op(32'h7F800000, 3'd0, 32'h7F800000, 5'h00, LAT_SPC, "R10 plus inf");
        run_op(32'hBF800000, 3'd0, QNAN, 5'h10, LAT_SPC, "R11 minus one");
        run_op(32'hFF800000, 3'd0, QNAN, 5'h10, LAT_SPC, "R11 minus inf");
        run_op(32'h80000001, 3'd0, QNAN, 5'h10, LAT_SPC, "R11 minus subnormal");
        run_op(32'h7FC00001, 3'd0, QNAN, 5'h00, LAT_SPC, "R12 quiet nan");
        run_op(32'hFFC00000, 3'd0, QNAN, 5'h00, LAT_SPC, "R12 negative quiet nan");
        run_op(32'h7F800001, 3'd0, QNAN, 5'h10, LAT_SPC, "R12 signalling nan");
    endtask

    task automatic t_busy_ignore;
        int n;
        int extra;
        @(negedge clk);
        operand = 32'h40800000; rmode = 3'd0; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        check(busy, "R2 busy after accept", {31'd0, busy}, 32'd1);
        n = 0;
        while (!done && n < 100) begin
            if (n == 5) begin
                operand = 32'h41100000; rmode = 3'd3; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk); @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(n == LAT_FIN, "R3 timing unchanged by start while busy", 32'(n), 32'(LAT_FIN));
        check(result == 32'h40000000, "R3 result unchanged by start while busy", result, 32'h40000000);
        extra = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); @(negedge clk);
            if (done || busy) extra++;
        end
        check(extra == 0, "R3 no done for ignored start", 32'(extra), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL R2 watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_exact();
        t_modes();
        t_subnormal();
        t_carry();
        t_specials();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule